// File: doc/BRIEF.md
# Quadrature Position Counter with Index Clearing

This block turns the two phase signals of an incremental rotary or linear encoder into a signed position count. It counts four times per encoder line, which means one count for every edge on either phase. It also reports the direction of the last valid step. A third input carries the encoder's once-per-revolution index mark. A rising edge on that input can clear the counter, depending on a two-bit clearing mode. The modes are: clear on every mark, clear only on the first mark after the marker flag was last cleared, or never clear.

All inputs must already be synchronous to the system clock. Index detection does not depend on the phase edges in any way. Because of this, an index edge cannot be lost when it falls close to a phase step. When an index clear and a count step land in the same clock, the clear wins.

An optional delay line of programmable length sits in front of the index edge detector. It lets the index be moved behind the phase edges when an encoder's mark leads its phases. A sticky flag records that an index mark has been seen, and a sticky error bit records any illegal step in which both phases change at once.

Top module: `qpos_index_counter`

## Requirements
- R1: While `rst_n` is low and just after it is released, `pos_count` is 0, `dir_up` is 1, `first_idx_flag` is 0 and `phase_err` is 0.
- R2: The count changes by exactly one on every clock in which exactly one of `phase_a`, `phase_b` differs from its value in the previous clock. The legal (A,B) cycle 00 -> 10 -> 11 -> 01 -> 00, with A leading B, counts up. The reverse order counts down. The change is visible after the edge that samples the new phase value.
- R3: `dir_up` is 1 after an up step and 0 after a down step, and holds its value when no valid step occurs.
- R4: A clock in which both phases change leaves the count unchanged and sets `phase_err`, which then stays 1 until reset.
- R5: With `clr_mode` = 2'b00, every rising edge of the (delayed) index loads 0 into the counter.
- R6: With `clr_mode` = 2'b10, a rising index edge loads 0 only while `first_idx_flag` is 0. Later index edges leave the count unchanged.
- R7: With `clr_mode` = 2'b01 or 2'b11, index edges never alter the count, and the count wraps modulo 2^CNT_W in both directions.
- R8: `first_idx_flag` becomes 1 after any rising index edge in any mode. It stays 1 until a cycle with `flag_clr` high and no index edge in that same cycle; an index edge in that cycle keeps it at 1.
- R9: Pulsing `flag_clr` re-arms the 2'b10 mode, so the next index edge clears the counter again.
- R10: An index clear in the same clock as a count step yields 0. An index edge arriving from one clock before to two clocks after a phase edge is never lost: the counter ends at 0 (or at +/-1 when the index came first) and the flag is set.
- R11: With `idx_delay` = d (0 to MAX_DLY, larger values saturate at MAX_DLY), an index rising edge sampled at clock edge k takes effect at edge k+d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_a | input | 1 | Encoder phase A, synchronized |
| phase_b | input | 1 | Encoder phase B, synchronized |
| index_in | input | 1 | Encoder index mark, synchronized |
| clr_mode | input | 2 | Index clearing mode: 00 every, 10 first only, 01/11 none |
| idx_delay | input | DLY_W | Index delay in clocks |
| flag_clr | input | 1 | One-cycle strobe that clears the first-index flag |
| pos_count | output | CNT_W | Position count |
| dir_up | output | 1 | Direction of last valid step (1 = up) |
| first_idx_flag | output | 1 | Sticky marker: an index edge was seen |
| phase_err | output | 1 | Sticky marker: both phases changed in one clock |

## Verification
The bench builds the counter with CNT_W = 8 and MAX_DLY = 4. With an 8-bit counter, a full sweep of more than 256 steps runs past the wrap point in both directions, with every intermediate value compared against modular arithmetic. The short delay line allows every delay setting, including a saturated out-of-range value, to be swept. Every index offset from one clock before to two clocks after a phase step is also tried against the clearing and flag behaviour.

// File: rtl/qpos_index_counter.sv
module qpos_index_counter #(
  parameter int CNT_W   = 32,
  parameter int MAX_DLY = 7,
  parameter int DLY_W   = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic [1:0]       clr_mode,
  input  logic [DLY_W-1:0] idx_delay,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] pos_count,
  output logic             dir_up,
  output logic             first_idx_flag,
  output logic             phase_err
);

  logic             a_q, b_q;
  logic [MAX_DLY:0] idx_line;
  logic             idx_prev;
  logic             idx_d;
  logic [DLY_W-1:0] dly_sel;

  wire a_chg   = phase_a ^ a_q;
  wire b_chg   = phase_b ^ b_q;
  wire one_chg = a_chg ^ b_chg;
  wire both    = a_chg & b_chg;
  wire step_up = a_chg ? (phase_a ^ phase_b) : ~(phase_a ^ phase_b);

  assign dly_sel     = (idx_delay > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : idx_delay;
  assign idx_line[0] = index_in;
  assign idx_d       = idx_line[dly_sel];

  wire idx_evt = idx_d & ~idx_prev;
  wire do_clr  = idx_evt & ((clr_mode == 2'b00) | ((clr_mode == 2'b10) & ~first_idx_flag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q                 <= 1'b0;
      b_q                 <= 1'b0;
      idx_line[MAX_DLY:1] <= '0;
      idx_prev            <= 1'b0;
      pos_count           <= '0;
      dir_up              <= 1'b1;
      first_idx_flag      <= 1'b0;
      phase_err           <= 1'b0;
    end else begin
      a_q                 <= phase_a;
      b_q                 <= phase_b;
      idx_line[MAX_DLY:1] <= idx_line[MAX_DLY-1:0];
      idx_prev            <= idx_d;
      if (do_clr)
        pos_count <= '0;
      else if (one_chg)
        pos_count <= step_up ? pos_count + 1'b1 : pos_count - 1'b1;
      if (one_chg)
        dir_up <= step_up;
      if (idx_evt)
        first_idx_flag <= 1'b1;
      else if (flag_clr)
        first_idx_flag <= 1'b0;
      if (both)
        phase_err <= 1'b1;
    end
  end

  assert_step_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (one_chg && !idx_evt) |=> (pos_count == $past(pos_count) + 1'b1 || pos_count == $past(pos_count) - 1'b1));

  assert_illegal_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (both && !idx_evt) |=> $stable(pos_count));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_err |=> phase_err);

  assert_every_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_evt && clr_mode == 2'b00) |=> (pos_count == '0));

  assert_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode[0] && !one_chg) |=> $stable(pos_count));

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (first_idx_flag && !flag_clr) |=> first_idx_flag);

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt |=> first_idx_flag);

endmodule

// File: tb/qpos_index_counter_tb.sv
module qpos_index_counter_tb;
  localparam int CNT_W = 8;
  localparam int MAX_DLY = 4;
  localparam int DLY_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, idx = 1'b0, fclr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [DLY_W-1:0] dly = '0;
  logic [CNT_W-1:0] pos;
  logic dir, flag, perr;

  int checks = 0;
  int errors = 0;
  int g = 0;
  int ep = 0;

  always #5 clk = ~clk;

  qpos_index_counter #(.CNT_W(CNT_W), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb), .index_in(idx),
    .clr_mode(mode), .idx_delay(dly), .flag_clr(fclr),
    .pos_count(pos), .dir_up(dir), .first_idx_flag(flag), .phase_err(perr));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mv: 0 hold, 1 up, -1 down, 2 both phases flip
  task automatic cyc(input int mv, input bit i, input bit c);
    @(negedge clk);
    g = (g + mv + 4) % 4;
    pa = (g == 1 || g == 2);
    pb = (g >= 2);
    idx = i;
    fclr = c;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pos", pos, 0); chk("R1 dir", dir, 1); chk("R1 flag", flag, 0); chk("R1 err", perr, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0);
    chk("R1 pos after release", pos, 0);

    // R7 wrap and R2 sweep in no-clear mode
    mode = 2'b01;
    cyc(-1, 0, 0);
    chk("R7 wrap down", pos, 255); chk("R3 dir down", dir, 0);
    ep = 255;
    for (int n = 0; n < 300; n++) begin
      cyc(1, 0, 0);
      ep = (ep + 1) % 256;
      chk("R2 up sweep", pos, ep);
    end
    chk("R3 dir up", dir, 1);
    for (int n = 0; n < 270; n++) begin
      cyc(-1, 0, 0);
      ep = (ep + 255) % 256;
      chk("R2 down sweep", pos, ep);
    end
    cyc(0, 0, 0);
    chk("R3 dir hold", dir, 0);
    // R7 index ignored in 01 and 11
    for (int m = 0; m < 2; m++) begin
      mode = (m == 0) ? 2'b01 : 2'b11;
      cyc(0, 1, 0); cyc(0, 0, 0);
      chk("R7 index ignored", pos, ep);
    end
    chk("R8 flag set by index", flag, 1);
    cyc(0, 0, 1);
    chk("R8 flag cleared", flag, 0);

    // R4 illegal step
    cyc(2, 0, 0);
    chk("R4 count held", pos, ep); chk("R4 err set", perr, 1);
    cyc(1, 0, 0);
    ep = (ep + 1) % 256;
    chk("R4 err sticky", perr, 1); chk("R2 after illegal", pos, ep);

    // R5 every index clears
    mode = 2'b00;
    for (int k = 0; k < 3; k++) begin
      cyc(1, 0, 0); cyc(1, 0, 0);
      cyc(0, 1, 0);
      chk("R5 cleared", pos, 0);
      cyc(0, 0, 0);
    end

    // R6 / R9 first-only mode
    mode = 2'b10;
    cyc(0, 0, 1);
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
    cyc(0, 1, 0); cyc(0, 0, 0);
    chk("R6 first index clears", pos, 0); chk("R8 flag", flag, 1);
    cyc(1, 0, 0); cyc(1, 0, 0);
    cyc(0, 1, 0); cyc(0, 0, 0);
    chk("R6 later index ignored", pos, 2);
    cyc(0, 1, 1); cyc(0, 0, 0);
    chk("R8 index beats clear", flag, 1); chk("R6 no clear while flagged", pos, 2);
    cyc(0, 0, 1);
    chk("R9 flag cleared", flag, 0);
    cyc(0, 1, 0); cyc(0, 0, 0);
    chk("R9 re-armed clear", pos, 0);

    // R10 window sweep
    mode = 2'b00;
    for (int o = -1; o <= 2; o++) begin
      cyc(0, 0, 1);
      cyc(1, 0, 0); cyc(1, 0, 0);
      for (int t = -1; t <= 2; t++) cyc((t == 0) ? 1 : 0, (t >= o), 0);
      cyc(0, 0, 0);
      chk("R10 window count", pos, (o < 0) ? 1 : 0);
      chk("R10 window flag", flag, 1);
    end

    // R11 delay sweep including saturated value
    for (int d = 0; d <= MAX_DLY + 1; d++) begin
      dly = DLY_W'(d);
      repeat (MAX_DLY + 2) cyc(0, 0, 0);
      cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
      for (int j = 0; j <= MAX_DLY; j++) begin
        cyc(0, 1, 0);
        chk("R11 delayed clear", pos, (j >= ((d > MAX_DLY) ? MAX_DLY : d)) ? 0 : 3);
      end
    end

    summary();
  end
endmodule